// File: doc/BRIEF.md
# SPI Master Peripheral With Status Flags

This block is a byte-wide SPI master that sits on the register bus of a small processor. Software picks the clock polarity, the clock phase and a serial clock rate. It then writes a byte into the data register, and that write starts an eight-bit exchange, most significant bit first. The block produces the serial clock from the system clock. It shifts the byte out on the serial output and, at the same time, collects eight bits from the serial input.

When the exchange completes, the received byte moves into a receive buffer. A completion flag is set and the interrupt request goes high. A write to the data register while a byte is still shifting is refused: the write-collision flag is set and the ongoing exchange carries on unchanged.

Software clears the two flags in one of two ways. It can read the status register and then access the data register. Each flag is cleared only if that status read saw it set. The completion flag alone can also be cleared by acknowledging the interrupt.

Top module: `spi_host`

## Requirements
- R1: After reset, the control, status and receive registers all read 0x00. The serial clock is low and the interrupt request is low.
- R2: A data-register write (address 2) starts an exchange only when the enable bit is set and no exchange is active. The written byte leaves on the serial output most significant bit first. The byte received on the serial input is assembled most significant bit first.
- R3: The control register is at address 0: bit 7 is enable, bit 3 is polarity, bit 2 is phase and bits 1:0 are the rate. The serial clock rests at the polarity level whenever no exchange is active.
- R4: Each exchange makes exactly 16 clock edges.
  - With phase 0, input is sampled on each edge leaving the rest level and output changes on each edge returning to it.
  - With phase 1, the roles of the two edges are swapped.
- R5: The serial clock half-period is 2, 8, 32 or 64 system clocks for rate 0 to 3. Setting the double-speed bit (status bit 0, writable) halves it. The fastest serial clock period is therefore two system clocks.
- R6: After the eighth sampling edge, the received byte is in the receive buffer, which reads at address 2. Status bit 7, the completion flag, is set and the interrupt request is high.
- R7: A data-register write during an active exchange sets status bit 6, the collision flag. The written byte is discarded and the byte being sent is not changed.
- R8: A status read (address 1) records which flags it saw set. The next data-register read or write clears only those recorded flags.
- R9: Pulsing the interrupt acknowledge input clears the completion flag and drops the interrupt request.
- R10: Status bits 5 to 1 always read as zero. The two flags cannot be written from the bus.
- R11: While the enable bit is clear, a data-register write is ignored: no clock edges appear and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus access strobe |
| wr | input | 1 | Write qualifier |
| rd | input | 1 | Read qualifier |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Completion interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears the completion flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume one bus access per cycle, with sel qualified by either rd or wr but never both. They also assume that the control register is not rewritten while an exchange is active, so the serial clock changes only on a half-period boundary.

The bench keeps to these conditions. It reconfigures the block only after an exchange has finished, and its slave model changes the serial input only on setup edges.

The bench sweeps all four modes, every rate and both speed settings. It then runs a collision in the middle of an exchange, the per-flag clear sequence, the interrupt acknowledge and a data write with the block disabled.

// File: rtl/spi_host.sv
module spi_host #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic          irq_ack,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);
  localparam int EW = $clog2(2*DW);
  localparam int BW = $clog2(DW);

  logic          en, cpol, cpha, dbl;
  logic [1:0]    rate;
  logic          busy, sck_r, done_f, col_f, arm_d, arm_c;
  logic [6:0]    cnt, base;
  logic [EW-1:0] ecnt;
  logic [DW-1:0] tx, rx, rbuf;

  always_comb
    case (rate)
      2'd0:    base = 7'd2;
      2'd1:    base = 7'd8;
      2'd2:    base = 7'd32;
      default: base = 7'd64;
    endcase

  wire [6:0] half      = dbl ? (base >> 1) : base;
  wire       ctrl_wr   = sel && wr && addr == 2'd0;
  wire       stat_wr   = sel && wr && addr == 2'd1;
  wire       stat_rd   = sel && rd && addr == 2'd1;
  wire       data_wr   = sel && wr && addr == 2'd2;
  wire       data_rd   = sel && rd && addr == 2'd2;
  wire       dacc      = data_wr || data_rd;
  wire       start     = data_wr && en && !busy;
  wire       collide   = data_wr && busy;
  wire       tick      = busy && en && (cnt == half - 7'd1);
  wire       samp      = tick && (ecnt[0] == cpha);
  wire       last_samp = samp && (ecnt[EW-1:1] == BW'(DW-1));
  wire       shift     = tick && (ecnt[0] != cpha) && (ecnt != '0);

  assign sck  = sck_r ^ cpol;
  assign mosi = tx[DW-1];
  assign irq  = done_f;

  always_comb
    case (addr)
      2'd0:    rdata = {en, 3'b000, cpol, cpha, rate};
      2'd1:    rdata = {done_f, col_f, 5'b00000, dbl};
      2'd2:    rdata = rbuf;
      default: rdata = '0;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; rate <= 2'd0; dbl <= 1'b0;
      busy <= 1'b0; sck_r <= 1'b0; cnt <= '0; ecnt <= '0;
      tx <= '0; rx <= '0; rbuf <= '0;
      done_f <= 1'b0; col_f <= 1'b0; arm_d <= 1'b0; arm_c <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en   <= wdata[7];
        cpol <= wdata[3];
        cpha <= wdata[2];
        rate <= wdata[1:0];
      end
      if (stat_wr) dbl <= wdata[0];

      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        ecnt  <= '0;
        sck_r <= 1'b0;
        tx    <= wdata;
      end else if (busy) begin
        if (!en) begin
          busy  <= 1'b0;
          sck_r <= 1'b0;
        end else if (tick) begin
          cnt   <= '0;
          sck_r <= ~sck_r;
          ecnt  <= ecnt + EW'(1);
          if (ecnt == EW'(2*DW-1)) busy <= 1'b0;
        end else begin
          cnt <= cnt + 7'd1;
        end
      end

      if (shift)     tx   <= {tx[DW-2:0], 1'b0};
      if (samp)      rx   <= {rx[DW-2:0], miso};
      if (last_samp) rbuf <= {rx[DW-2:0], miso};

      if (stat_rd) begin
        arm_d <= done_f;
        arm_c <= col_f;
      end else if (dacc) begin
        arm_d <= 1'b0;
        arm_c <= 1'b0;
      end
      if (irq_ack) arm_d <= 1'b0;

      if (last_samp)                      done_f <= 1'b1;
      else if (irq_ack || (dacc && arm_d)) done_f <= 1'b0;

      if (collide)              col_f <= 1'b1;
      else if (dacc && arm_c)   col_f <= 1'b0;
    end
  end

  a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  a_r5_sck_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && !tick && !ctrl_wr) |=> $stable(sck));

  a_r6_done_from_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(busy));

  a_r7_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> col_f);

  a_r7_tx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !shift) |=> tx == $past(tx));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !last_samp) |=> !irq);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd1) |-> rdata[5:1] == 5'd0);
endmodule

// File: tb/spi_host_bench.sv
module spi_host_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic       irq, irq_ack = 1'b0, sck, mosi, miso = 1'b0;

  spi_host u_spi_host (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .irq_ack(irq_ack),
    .sck(sck), .mosi(mosi), .miso(miso));

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0; rd = 1'b0;
  endtask

  logic [7:0] stx, srx;
  int  nedge, bad_int, s_half;
  time last_t;
  bit  sl_on = 1'b0, s_cpol, s_cpha;

  always @(sck) begin : slave
    bit lead;
    if (sl_on) begin
      lead = (sck != s_cpol);
      if (nedge > 0 && ($time - last_t) != time'(s_half * 8)) bad_int++;
      last_t = $time;
      nedge++;
      if (lead == !s_cpha) srx = {srx[6:0], mosi};
      else if (s_cpha) begin miso = stx[7]; stx = stx << 1; end
      else begin stx = stx << 1; miso = stx[7]; end
    end
  end

  function automatic int half_of(input int rt, input bit db);
    int b;
    b = (rt == 3) ? 64 : (2 << (2 * rt));
    return db ? b / 2 : b;
  endfunction

  task automatic arm_slave(input bit cp, input bit ph, input int rt, input bit db,
                           input logic [7:0] mi);
    s_cpol = cp; s_cpha = ph; s_half = half_of(rt, db);
    stx = mi; srx = 8'd0; nedge = 0; bad_int = 0;
    miso = ph ? 1'b0 : mi[7];
    sl_on = 1'b1;
  endtask

  task automatic xfer(input bit cp, input bit ph, input int rt, input bit db,
                      input logic [7:0] mo, input logic [7:0] mi);
    logic [7:0] v;
    bus_wr(2'd0, {1'b1, 3'b000, cp, ph, 2'(rt)});
    bus_wr(2'd1, {7'd0, db});
    arm_slave(cp, ph, rt, db, mi);
    check(sck == cp, "R3 idle level", sck, cp);
    bus_wr(2'd2, mo);
    repeat (16 * s_half + 4) @(negedge clk);
    sl_on = 1'b0;
    check(nedge == 16, "R4 edge count", nedge, 16);
    check(bad_int == 0, "R5 half period", bad_int, 0);
    check(srx == mo, "R2 mosi byte", srx, mo);
    check(irq == 1'b1, "R6 irq", irq, 1);
    check(sck == cp, "R3 rest after", sck, cp);
    bus_rd(2'd1, v);
    check(v == {1'b1, 6'd0, db}, "R6 R10 status", v, {1'b1, 6'd0, db});
    bus_rd(2'd2, v);
    check(v == mi, "R6 R4 rx byte", v, mi);
    bus_rd(2'd1, v);
    check(v == {7'd0, db}, "R8 flag cleared", v, {7'd0, db});
    check(irq == 1'b0, "R8 irq cleared", irq, 0);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_rd(2'd0, v); check(v == 8'd0, "R1 ctrl", v, 0);
    bus_rd(2'd1, v); check(v == 8'd0, "R1 status", v, 0);
    bus_rd(2'd2, v); check(v == 8'd0, "R1 rx", v, 0);
    check(sck == 1'b0 && irq == 1'b0, "R1 pins", {sck, irq}, 0);

    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, v); check(v == 8'h01, "R10 status write", v, 8'h01);
    bus_wr(2'd1, 8'h00);

    for (int m = 0; m < 4; m++)
      for (int rt = 0; rt < 4; rt++)
        for (int db = 0; db < 2; db++) begin
          int i;
          i = m * 8 + rt * 2 + db;
          xfer(m[1], m[0], rt, db[0], 8'(8'hA5 ^ (i * 37)), 8'(8'h3C + i * 29));
        end

    bus_wr(2'd0, 8'h83);
    bus_wr(2'd1, 8'h00);
    arm_slave(1'b0, 1'b0, 3, 1'b0, 8'h96);
    bus_wr(2'd2, 8'hC3);
    repeat (100) @(negedge clk);
    bus_wr(2'd2, 8'h5A);
    bus_rd(2'd1, v); check(v == 8'h40, "R7 collision flag", v, 8'h40);
    repeat (16 * 64 + 4) @(negedge clk);
    sl_on = 1'b0;
    check(srx == 8'hC3, "R7 byte kept", srx, 8'hC3);
    check(irq == 1'b1, "R6 irq after collision", irq, 1);
    bus_rd(2'd2, v); check(v == 8'h96, "R6 rx after collision", v, 8'h96);
    bus_rd(2'd1, v); check(v == 8'h80, "R8 only armed flag cleared", v, 8'h80);

    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check(irq == 1'b0, "R9 ack drops irq", irq, 0);
    bus_rd(2'd1, v); check(v == 8'h00, "R9 ack clears flag", v, 0);

    bus_wr(2'd0, 8'h00);
    arm_slave(1'b0, 1'b0, 0, 1'b0, 8'h00);
    bus_wr(2'd2, 8'h3C);
    repeat (300) @(negedge clk);
    sl_on = 1'b0;
    check(nedge == 0, "R11 no edges", nedge, 0);
    check(irq == 1'b0, "R11 no irq", irq, 0);
    bus_rd(2'd1, v); check(v == 8'h00, "R11 no flags", v, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule